// File: doc/BRIEF.md
# Bit-Serial Link to Byte Port Bridge

This block joins a point-to-point serial link, one wire in and one wire out, to two byte-wide parallel ports, one for each direction. Bytes to send arrive on a transmit port. Each byte leaves as a data frame, and the next byte is held back until the far end answers with a short acknowledge frame. Frames arriving on the serial input are decoded. A data frame puts its byte on the receive port. An acknowledge frame releases the byte currently in flight.

Flow control works one byte at a time. The block sends an acknowledge for a received byte only after the local consumer has taken it, so the far end can never overrun the single receive holding register. One system clock runs the whole block. A rate input selects 8 clock cycles per bit (fast rate) or 16 (base rate). The receiver looks at the synchronised line eight times per bit and decides each bit at its middle.

Top module: `link_adapter`

## Requirements
- R1: The serial output idles low. A data frame is sent as a high start bit, a type bit of 1, the eight data bits least significant bit first, and a low stop bit.
- R2: An acknowledge frame is sent as a high start bit, a type bit of 0 and a low stop bit, three bits in all.
- R3: With `rate_fast` high every bit lasts 8 clock cycles. With it low every bit lasts 16. This holds for both sending and receiving.
- R4: A received data byte appears on `rx_data` with `rx_valid` high. Both stay unchanged until a clock edge sees `rx_ack` high, and `rx_valid` falls after that edge.
- R5: An acknowledge frame for a received byte is sent only after the consumer has taken the byte, and exactly one is sent for each byte.
- R6: A byte on `tx_data` is taken while `tx_valid` is high and no byte is in flight, and exactly one data frame is sent for it. `tx_ack` stays low until the far end's acknowledge frame arrives. It then stays high until `tx_valid` goes low, and no further frame is sent for the held request.
- R7: When an acknowledge frame and a data frame are both waiting to be sent, the acknowledge frame is sent first.
- R8: The receiver ends an acknowledge frame after its three bits, so a data frame whose start bit directly follows an acknowledge's stop bit is decoded correctly.
- R9: A frame whose stop bit is high sets `link_err`. The flag stays high until reset. The frame produces no `rx_valid` and no acknowledge frame, and later good frames are still decoded.
- R10: After reset `link_out`, `rx_valid`, `tx_ack` and `link_err` are all low.
- R11: A high pulse on `link_in` that lasts shorter than half a bit is rejected at the mid-bit check of the start bit. It produces no byte and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 8 times the fast bit rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_fast | input | 1 | 1: 8 clocks per bit, 0: 16 clocks per bit |
| link_in | input | 1 | Serial line from the far end |
| link_out | output | 1 | Serial line to the far end |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte is waiting |
| rx_ack | input | 1 | Consumer takes the received byte |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte to send is presented |
| tx_ack | output | 1 | Far end has acknowledged the byte |
| link_err | output | 1 | Sticky bad-stop-bit flag |

## Verification
A receiver sampling phase that has drifted or a wrong bit count shows up within one frame: `rx_data` holds the wrong byte, or a frame boundary is missed and the next frame is lost. A stuck acknowledge-pending or in-flight flag shows up at the serial output. It appears either as an acknowledge frame that never comes or comes twice, or as `tx_ack` failing to rise, or as a repeated data frame, all by the end of the next frame time. The scoreboard decodes every frame on `link_out` and matches it in order against what the requirements predict, so a frame in the wrong order or an extra frame is reported as soon as its stop bit is sampled.

// File: rtl/link_pkg.sv
package link_pkg;
  localparam int DATA_W   = 8;
  localparam int OSR      = 8;
  localparam int SLOW_DIV = 2;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RUN  = 2'd1,
    RX_HOLD = 2'd2
  } rx_state_t;
endpackage

// File: rtl/link_tick.sv
module link_tick #(
  parameter int SLOW_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rate_fast,
  output logic tick
);
  localparam int DVW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DVW-1:0] DV_LAST = DVW'(SLOW_DIV - 1);

  logic [DVW-1:0] div;

  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= '0;
      tick <= 1'b0;
    end else if (rate_fast) begin
      div  <= '0;
      tick <= 1'b1;
    end else begin
      tick <= (div == DV_LAST);
      div  <= (div == DV_LAST) ? '0 : div + 1'b1;
    end
  end

  assert_fast_tick_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rate_fast)) |-> tick);

  generate
    if (SLOW_DIV > 1) begin : g_slow_chk
      assert_slow_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && !rate_fast) |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OSR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line_in,
  output logic          data_stb,
  output logic [DW-1:0] data_byte,
  output logic          ack_stb,
  output logic          err
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 3);
  localparam logic [CW-1:0] C_MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] I_LAST_DATA = BW'(DW + 1);

  logic s1, s2;
  rx_state_t st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] idx;
  logic is_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      is_data   <= 1'b0;
      data_byte <= '0;
      data_stb  <= 1'b0;
      ack_stb   <= 1'b0;
      err       <= 1'b0;
    end else begin
      data_stb <= 1'b0;
      ack_stb  <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (s2) begin
            st  <= RX_RUN;
            cnt <= '0;
            idx <= '0;
          end
          RX_RUN: begin
            cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
            if (cnt == C_MID) begin
              idx <= idx + 1'b1;
              if (idx == '0) begin
                if (!s2) st <= RX_IDLE;
              end else if (idx == BW'(1)) begin
                is_data <= s2;
              end else if (is_data && idx <= I_LAST_DATA) begin
                data_byte <= {s2, data_byte[DW-1:1]};
              end else begin
                if (s2) begin
                  err <= 1'b1;
                  st  <= RX_HOLD;
                end else begin
                  st <= RX_IDLE;
                  if (is_data) data_stb <= 1'b1;
                  else         ack_stb  <= 1'b1;
                end
              end
            end
          end
          default: if (!s2) st <= RX_IDLE;
        endcase
      end
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  assert_one_result_R8: assert property (@(posedge clk) disable iff (rst)
    !(data_stb && ack_stb));
  assert_hold_after_err_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !data_stb && !ack_stb);
endmodule

// File: rtl/link_tx.sv
module link_tx #(
  parameter int DW  = 8,
  parameter int OSR = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          ack_req,
  input  logic          far_ack,
  input  logic          tx_valid,
  input  logic [DW-1:0] tx_data,
  output logic          tx_ack,
  output logic          line_out
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OSR);
  localparam int NW = $clog2(FW + 1);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

  logic busy, ack_pend, waiting;
  logic [CW-1:0] cnt;
  logic [NW-1:0] left;
  logic [FW-2:0] sh;

  wire ack_want = ack_pend || ack_req;
  wire go_ack   = tick && !busy && ack_want;
  wire go_data  = tick && !busy && !ack_want && tx_valid && !waiting && !tx_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_pend <= 1'b0;
      waiting  <= 1'b0;
      tx_ack   <= 1'b0;
    end else begin
      if (go_ack)       ack_pend <= 1'b0;
      else if (ack_req) ack_pend <= 1'b1;
      if (go_data) waiting <= 1'b1;
      else if (waiting && far_ack) waiting <= 1'b0;
      if (waiting && far_ack)       tx_ack <= 1'b1;
      else if (tx_ack && !tx_valid) tx_ack <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      line_out <= 1'b0;
      cnt      <= '0;
      left     <= '0;
      sh       <= '0;
    end else if (go_ack || go_data) begin
      busy     <= 1'b1;
      line_out <= 1'b1;
      cnt      <= '0;
      left     <= go_ack ? NW'(2) : NW'(FW - 1);
      sh       <= go_ack ? '0 : {1'b0, tx_data, 1'b1};
    end else if (busy && tick) begin
      if (cnt == C_LAST) begin
        cnt <= '0;
        if (left == '0) begin
          busy     <= 1'b0;
          line_out <= 1'b0;
        end else begin
          line_out <= sh[0];
          sh       <= sh >> 1;
          left     <= left - 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);
  assert_ack_first_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !busy && ack_want) |=> (busy && left == NW'(2)));
  assert_ack_held_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_ack && tx_valid) |=> tx_ack);
  assert_wait_far_R6: assert property (@(posedge clk) disable iff (rst)
    (waiting && !far_ack) |=> (waiting && !tx_ack));
endmodule

// File: rtl/link_adapter.sv
module link_adapter #(
  parameter int DATA_W   = link_pkg::DATA_W,
  parameter int OSR      = link_pkg::OSR,
  parameter int SLOW_DIV = link_pkg::SLOW_DIV
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rate_fast,
  input  logic              link_in,
  output logic              link_out,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ack,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ack,
  output logic              link_err
);
  logic tick;
  logic rx_stb, far_ack;
  logic [DATA_W-1:0] rx_byte;

  wire taken = rx_valid && rx_ack;

  link_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .rate_fast(rate_fast), .tick(tick)
  );

  link_rx #(.DW(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line_in(link_in),
    .data_stb(rx_stb), .data_byte(rx_byte), .ack_stb(far_ack), .err(link_err)
  );

  link_tx #(.DW(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .ack_req(taken), .far_ack(far_ack),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ack(tx_ack), .line_out(link_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      if (taken) rx_valid <= 1'b0;
      if (rx_stb && !rx_valid) begin
        rx_valid <= 1'b1;
        rx_data  <= rx_byte;
      end
    end
  end

  assert_rx_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data)));
  assert_rx_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ack && !rx_stb) |=> !rx_valid);
endmodule

// File: tb/sim_link_adapter.sv
module sim_link_adapter;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst = 1'b1, rate_fast = 1'b1, drv_line = 1'b0, loop_en = 1'b0;
  logic rx_ack = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic link_out, rx_valid, tx_ack, link_err;
  logic [7:0] rx_data;
  wire link_in = loop_en ? link_out : drv_line;

  int n_tests = 0, n_fail = 0, bitclk = 8;
  bit done = 1'b0;
  logic [8:0] exp_q[$];

  always #(CLK_NS/2) clk = ~clk;

  link_adapter u0 (
    .clk(clk), .rst(rst), .rate_fast(rate_fast), .link_in(link_in), .link_out(link_out),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ack(tx_ack), .link_err(link_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Line monitor: decodes every frame on link_out and pops the scoreboard.
  always begin : mon
    logic [7:0] b;
    logic typ, stp;
    @(negedge clk);
    if (!rst && link_out) begin
      b = 8'h00;
      repeat (bitclk/2) @(negedge clk);
      repeat (bitclk) @(negedge clk);
      typ = link_out;
      if (typ) for (int i = 0; i < 8; i++) begin
        repeat (bitclk) @(negedge clk);
        b[i] = link_out;
      end
      repeat (bitclk) @(negedge clk);
      stp = link_out;
      check(stp == 1'b0, "R1 R2 stop bit low", stp, 0);
      if (exp_q.size() == 0) check(1'b0, "R5 R6 unexpected frame", {typ, b}, 0);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check({typ, b} == e, "R1 R2 R7 frame order/content", {typ, b}, e);
      end
    end
  end

  task automatic drive_bit(input logic v);
    drv_line = v;
    repeat (bitclk) @(negedge clk);
  endtask

  task automatic send_frame(input logic is_data, input logic [7:0] b, input logic stop_v);
    drive_bit(1'b1);
    drive_bit(is_data);
    if (is_data) for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit(stop_v);
    drv_line = 1'b0;
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 600 && !rx_valid; i++) @(negedge clk);
  endtask

  task automatic wait_txack();
    for (int i = 0; i < 600 && !tx_ack; i++) @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 800 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3 * bitclk) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic take_rx();
    exp_q.push_back(9'h000);
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    check(rx_valid == 1'b0, "R4 rx_valid drops after take", rx_valid, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog R6: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (5) @(negedge clk);
    check(link_out == 0 && rx_valid == 0 && tx_ack == 0 && link_err == 0,
          "R10 reset state", {link_out, rx_valid, tx_ack, link_err}, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1 receive path, R4 hold, R5 ack only after take
    send_frame(1'b1, 8'hA5, 1'b0);
    wait_rx();
    check(rx_valid && rx_data == 8'hA5, "R4 received byte", rx_data, 8'hA5);
    repeat (60) @(negedge clk);
    check(rx_valid && rx_data == 8'hA5, "R4 byte held without ack", rx_data, 8'hA5);
    check(exp_q.size() == 0, "R5 no early ack frame", exp_q.size(), 0);
    take_rx();
    drain("R5 ack frame after take");

    // R6 transmit path; R8 ack followed immediately by data
    exp_q.push_back({1'b1, 8'h3C});
    tx_data = 8'h3C;
    tx_valid = 1'b1;
    drain("R6 data frame sent");
    repeat (30) @(negedge clk);
    check(tx_ack == 1'b0, "R6 tx_ack low before far ack", tx_ack, 0);
    send_frame(1'b0, 8'h00, 1'b0);
    send_frame(1'b1, 8'h81, 1'b0);
    check(tx_ack == 1'b1, "R6 tx_ack after far ack", tx_ack, 1);
    wait_rx();
    check(rx_valid && rx_data == 8'h81, "R8 data right after ack", rx_data, 8'h81);
    repeat (40) @(negedge clk);
    check(tx_ack == 1'b1, "R6 tx_ack held while valid", tx_ack, 1);
    tx_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(tx_ack == 1'b0, "R6 tx_ack clears", tx_ack, 0);
    take_rx();
    drain("R6 R5 no repeat data frame");

    // R7 priority: take and new byte in the same cycle
    send_frame(1'b1, 8'h42, 1'b0);
    wait_rx();
    check(rx_data == 8'h42, "R7 setup byte", rx_data, 8'h42);
    exp_q.push_back(9'h000);
    exp_q.push_back({1'b1, 8'h99});
    tx_data = 8'h99;
    tx_valid = 1'b1;
    rx_ack = 1'b1;
    @(negedge clk);
    rx_ack = 1'b0;
    drain("R7 ack before data");
    send_frame(1'b0, 8'h00, 1'b0);
    wait_txack();
    check(tx_ack == 1'b1, "R7 tx_ack", tx_ack, 1);
    tx_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R9 bad stop bit
    send_frame(1'b1, 8'h77, 1'b1);
    repeat (40) @(negedge clk);
    check(link_err == 1'b1, "R9 error flagged", link_err, 1);
    check(rx_valid == 1'b0, "R9 frame discarded", rx_valid, 0);
    repeat (100) @(negedge clk);
    check(link_err == 1'b1 && exp_q.size() == 0, "R9 sticky, no ack", link_err, 1);

    // R11 short glitch
    drv_line = 1'b1;
    @(negedge clk);
    drv_line = 1'b0;
    repeat (120) @(negedge clk);
    check(rx_valid == 1'b0, "R11 glitch rejected", rx_valid, 0);

    // R3 base rate both ways; R9 later frames still decoded
    rate_fast = 1'b0;
    bitclk = 16;
    repeat (20) @(negedge clk);
    send_frame(1'b1, 8'hC3, 1'b0);
    wait_rx();
    check(rx_valid && rx_data == 8'hC3, "R3 R9 slow rate receive", rx_data, 8'hC3);
    take_rx();
    drain("R3 slow rate ack frame");

    // R3 fast rate loopback: data, take, ack returns
    rate_fast = 1'b1;
    bitclk = 8;
    repeat (20) @(negedge clk);
    loop_en = 1'b1;
    exp_q.push_back({1'b1, 8'h5A});
    tx_data = 8'h5A;
    tx_valid = 1'b1;
    wait_rx();
    check(rx_valid && rx_data == 8'h5A, "R1 R3 loopback byte", rx_data, 8'h5A);
    take_rx();
    wait_txack();
    check(tx_ack == 1'b1, "R6 loopback ack", tx_ack, 1);
    tx_valid = 1'b0;
    drain("R6 loopback frames");
    loop_en = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule